// File: doc/BRIEF.md
# Center-Aligned Multichannel PWM Timer

This block produces several pulse-width-modulated outputs whose pulses all share one center. A single counter sweeps upward from a programmable start value to a programmable top value and then sweeps back down to the start value, without end. Each channel compares the counter with its own threshold. The crossing on the way down switches the channel's pulse on. The crossing on the way up switches it off. The pulse is therefore symmetric about the instant when the counter sits at the start value.

Every crossing also latches a sticky per-channel event flag. Software clears a flag by writing 1 to its bit. A single interrupt line is active while any flag whose enable is set is still pending. A channel can drive a high-true or a low-true waveform. It can also release its pin: its output-enable drops, but it still flags and interrupts. The top value and the thresholds are written into holding registers first. Those values take effect only when the counter reaches the top, so a period is never cut short by a write.

Top module: `cpwm_timer`

## Requirements
- R1: After a valid configuration (start value S, top value T, S < T ≤ 0x7FFF), the counter steps up by one per clock from S to T and then down by one to S, and repeats. The PWM period is 2·(T−S) clocks. If T ≤ S, the counter is held at S and no channel event occurs.
- R2: For a high-true channel with threshold C and S < C < T, the output rises one clock after the counter equals C while it is falling. It falls one clock after the counter equals C while it is rising. The output therefore stays high for 2·(C−S) clocks in each period.
- R3: Every counter/threshold equality, whether the counter is rising or falling, sets that channel's flag on the next clock. The flag stays set until it is cleared.
- R4: Writing a data word to the flag-clear address clears each flag whose data bit (bit n for channel n) is 1. An equality in the same clock wins, and the flag stays set.
- R5: `irq` is high exactly when some channel has both its flag and its interrupt enable set.
- R6: Output select 2'b00 drives `pwm_oe[n]` low and `pwm_out[n]` low, while the channel's flag and interrupt still behave as in R3 and R5.
- R7: Output select 2'b01 or 2'b11 drives the inverse of the R2 waveform (low-true), and select 2'b10 drives the R2 waveform. Both drive `pwm_oe[n]` high.
- R8: Writes to the top value and to the thresholds go to holding registers. They become active on the clock edge at which the counter equals the active top value, or on any edge while the counter is held (R1). Start-value and control writes take effect at once.
- R9: A threshold equal to S keeps a high-true output low (0 % duty). A threshold equal to T keeps it high (100 % duty).
- R10: While `rst` is high and after it is released, all flags, `irq`, `pwm_out` and `pwm_oe` are 0, and every register is 0.
- R11: Register addresses: 0 = start value, 1 = top value, 2 = flag clear, 4+2n = threshold of channel n, 5+2n = control of channel n. The control word holds the output select in bits 1:0 and the interrupt enable in bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address (R11) |
| wr_data | input | CW | Write data |
| pwm_out | output | NCH | Channel waveform outputs |
| pwm_oe | output | NCH | Channel output enables |
| flag | output | NCH | Sticky per-channel event flags |
| irq | output | 1 | Combined interrupt request |

## Verification
A behavioural model runs alongside the design and is compared on every clock. The first pattern uses a nonzero start value with four channels programmed as a mid-range high-true pulse, a threshold at the start value, a threshold at the top, and a low-true pulse. Measured pulse and period lengths separate a correct symmetric sweep from an off-by-one at either turning point. A later top-value write made in the middle of a period shows whether the holding register waits for the turning point. Switching a channel to the released mode, and clearing flags with interrupts disabled, tell the flag path apart from the pin path.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // Per-channel control word: output select in [1:0], interrupt enable in [2]
  typedef struct packed {
    logic       ie;
    logic [1:0] osel;
  } chan_ctl_t;

  localparam int CTL_W     = 3;
  localparam int ADR_START = 0;
  localparam int ADR_TOP   = 1;
  localparam int ADR_CLR   = 2;
  localparam int ADR_CH0   = 4;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    load,
  output logic [CW-1:0]           start_q,
  output logic [CW-1:0]           top_q,
  output logic [NCH-1:0][CW-1:0]  thr_q,
  output chan_ctl_t [NCH-1:0]     ctl_q,
  output logic [NCH-1:0]          clr_mask
);
  logic [CW-1:0] top_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      top_q    <= '0;
      top_hold <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(ADR_START)) start_q <= wr_data;
      if (wr_en && wr_addr == AW'(ADR_TOP))   top_hold <= wr_data;
      if (load) top_q <= top_hold;
    end
  end

  assign clr_mask = (wr_en && wr_addr == AW'(ADR_CLR)) ? wr_data[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_THR = AW'(ADR_CH0 + 2*i);
    localparam logic [AW-1:0] A_CTL = AW'(ADR_CH0 + 2*i + 1);
    logic [CW-1:0] thr_hold;

    always_ff @(posedge clk) begin
      if (rst) begin
        thr_hold <= '0;
        thr_q[i] <= '0;
        ctl_q[i] <= '0;
      end else begin
        if (wr_en && wr_addr == A_THR) thr_hold <= wr_data;
        if (load) thr_q[i] <= thr_hold;
        if (wr_en && wr_addr == A_CTL) ctl_q[i] <= chan_ctl_t'(wr_data[CTL_W-1:0]);
      end
    end

    assert_thr_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !load |=> thr_q[i] == $past(thr_q[i]));
  end

  assert_top_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> top_q == $past(top_q));
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] start_q,
  input  logic [CW-1:0] top_q,
  output logic [CW-1:0] cnt_q,
  output logic          up_q,
  output logic          run,
  output logic          at_top,
  output logic          at_start,
  output logic          load
);
  assign run      = top_q > start_q;
  assign at_top   = run && cnt_q == top_q;
  assign at_start = run && cnt_q == start_q;
  assign load     = at_top || !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!run) begin
      cnt_q <= start_q;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= top_q) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q <= start_q) begin
        up_q  <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_turn_down_R1: assert property (@(posedge clk) disable iff (rst)
    at_top |=> !up_q);
  assert_up_step_R1: assert property (@(posedge clk) disable iff (rst)
    (run && up_q && cnt_q < top_q) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_turn_up_R1: assert property (@(posedge clk) disable iff (rst)
    (at_start && !up_q) |=> up_q);
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_q,
  input  logic          up_q,
  input  logic          run,
  input  logic          at_top,
  input  logic          at_start,
  input  logic [CW-1:0] thr,
  input  chan_ctl_t     ctl,
  input  logic          clr,
  output logic          pwm,
  output logic          oe,
  output logic          flag_q
);
  logic hit, set_ev, clr_ev, lvl_q;

  assign hit    = run && cnt_q == thr;
  // At the top the pulse is switched on; at the start value it is switched off
  assign set_ev = hit && ((!up_q && !at_start) || at_top);
  assign clr_ev = hit && ((up_q && !at_top) || at_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (set_ev)      lvl_q <= 1'b1;
      else if (clr_ev) lvl_q <= 1'b0;
      if (hit)         flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
    end
  end

  assign oe  = |ctl.osel;
  assign pwm = ctl.osel[0] ? ~lvl_q : (ctl.osel[1] & lvl_q);

  assert_lvl_moves_on_match_R2: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> $past(hit));
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  assert_released_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !pwm);
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int  NCH = 4,
  parameter int  CW  = 16,
  localparam int AW  = $clog2(ADR_CH0 + 2*NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_oe,
  output logic [NCH-1:0] flag,
  output logic           irq
);
  logic [CW-1:0]          start_q, top_q, cnt_q;
  logic [NCH-1:0][CW-1:0] thr_q;
  chan_ctl_t [NCH-1:0]    ctl_q;
  logic [NCH-1:0]         clr_mask, ie_vec;
  logic                   up_q, run, at_top, at_start, load;

  cpwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .start_q(start_q), .top_q(top_q), .thr_q(thr_q),
    .ctl_q(ctl_q), .clr_mask(clr_mask)
  );

  cpwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .start_q(start_q), .top_q(top_q), .cnt_q(cnt_q),
    .up_q(up_q), .run(run), .at_top(at_top), .at_start(at_start), .load(load)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    cpwm_channel #(.CW(CW)) u_chan (
      .clk(clk), .rst(rst), .cnt_q(cnt_q), .up_q(up_q), .run(run),
      .at_top(at_top), .at_start(at_start), .thr(thr_q[i]), .ctl(ctl_q[i]),
      .clr(clr_mask[i]), .pwm(pwm_out[i]), .oe(pwm_oe[i]), .flag_q(flag[i])
    );
    assign ie_vec[i] = ctl_q[i].ie;
  end

  assign irq = |(flag & ie_vec);

  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> |flag);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(rst) |-> (flag == '0 && !irq && pwm_oe == '0));
endmodule

// File: tb/tb_cpwm_timer.sv
module tb_cpwm_timer;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = $clog2(4 + 2*NCH);
  localparam int WATCHDOG = 100000;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [AW-1:0]  wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_out, pwm_oe, flag;
  logic irq;

  cpwm_timer #(.NCH(NCH), .CW(CW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .flag(flag), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, done = 0;

  // Behavioural model
  int m_start, m_top, m_top_h, m_cnt;
  bit m_up;
  int m_thr[NCH], m_thr_h[NCH], m_osel[NCH];
  bit m_ie[NCH], m_lvl[NCH], m_flag[NCH];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_start = 0; m_top = 0; m_top_h = 0; m_cnt = 0; m_up = 1;
      for (int i = 0; i < NCH; i++) begin
        m_thr[i] = 0; m_thr_h[i] = 0; m_osel[i] = 0; m_ie[i] = 0;
        m_lvl[i] = 0; m_flag[i] = 0;
      end
      started = 1;
    end else begin
      bit running, ld;
      int top_h_old;
      int thr_h_old[NCH];
      running = m_top > m_start;
      ld = !running || (m_cnt == m_top);
      for (int i = 0; i < NCH; i++) begin
        bit eq, clrw;
        eq = running && m_cnt == m_thr[i];
        clrw = wr_en && wr_addr == 2 && wr_data[i];
        if (eq) begin
          if (m_cnt == m_start) m_lvl[i] = 0;
          else if (m_cnt == m_top) m_lvl[i] = 1;
          else m_lvl[i] = !m_up;
          m_flag[i] = 1;
        end else if (clrw) m_flag[i] = 0;
      end
      if (!running) begin m_cnt = m_start; m_up = 1; end
      else if (m_up) begin
        if (m_cnt >= m_top) begin m_up = 0; m_cnt--; end else m_cnt++;
      end else begin
        if (m_cnt <= m_start) begin m_up = 1; m_cnt++; end else m_cnt--;
      end
      top_h_old = m_top_h;
      for (int i = 0; i < NCH; i++) thr_h_old[i] = m_thr_h[i];
      if (wr_en) begin
        if (wr_addr == 0) m_start = wr_data;
        if (wr_addr == 1) m_top_h = wr_data;
        for (int i = 0; i < NCH; i++) begin
          if (wr_addr == AW'(4 + 2*i)) m_thr_h[i] = wr_data;
          if (wr_addr == AW'(5 + 2*i)) begin
            m_osel[i] = wr_data[1:0];
            m_ie[i] = wr_data[2];
          end
        end
      end
      if (ld) begin
        m_top = top_h_old;
        for (int i = 0; i < NCH; i++) m_thr[i] = thr_h_old[i];
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      bit exp_irq;
      exp_irq = 0;
      for (int i = 0; i < NCH; i++) begin
        bit eo, ee;
        ee = m_osel[i] != 0;
        eo = m_osel[i][0] ? !m_lvl[i] : (m_osel[i][1] && m_lvl[i]);
        check(pwm_out[i] == eo, "R2", $sformatf("pwm_out[%0d]", i), pwm_out[i], eo);
        check(pwm_oe[i] == ee, "R6", $sformatf("pwm_oe[%0d]", i), pwm_oe[i], ee);
        check(flag[i] == m_flag[i], "R3", $sformatf("flag[%0d]", i), flag[i], m_flag[i]);
        if (m_flag[i] && m_ie[i]) exp_irq = 1;
      end
      check(irq == exp_irq, "R5", "irq", irq, exp_irq);
    end
  end

  // Pulse/period monitors on channel 0 (high-true) and channel 3 (low-true)
  int rise0 = -1, per0 = 0, hi0 = 0, wid0 = 0, lo3 = 0, wid3 = 0;
  bit prev0 = 0, prev3 = 1;
  always @(negedge clk) begin
    if (!rst) begin
      if (pwm_out[0] && !prev0) begin
        if (rise0 >= 0) per0 = cyc - rise0;
        rise0 = cyc;
      end
      if (pwm_out[0]) hi0++;
      else if (prev0) begin wid0 = hi0; hi0 = 0; end
      if (!pwm_out[3]) lo3++;
      else if (!prev3) begin wid3 = lo3; lo3 = 0; end
      prev0 = pwm_out[0];
      prev3 = pwm_out[3];
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      report();
    end
  end

  initial begin
    idle(4);
    // R10: reset state
    check(flag == 0 && irq == 0 && pwm_out == 0 && pwm_oe == 0, "R10", "reset outputs",
          {flag, pwm_out, pwm_oe}, 0);
    rst = 0;
    idle(2);
    check(flag == 0 && irq == 0 && pwm_oe == 0, "R10", "after release", {flag, pwm_oe}, 0);

    // R11 map: ch0 thr 8 high-true ie; ch1 thr=start; ch2 thr=top; ch3 thr 6 low-true
    wr(4, 8);  wr(5, 3'b110);
    wr(6, 3);  wr(7, 3'b010);
    wr(8, 13); wr(9, 3'b010);
    wr(10, 6); wr(11, 3'b001);
    wr(0, 3);  wr(1, 13);
    idle(70);
    check(per0 == 20, "R1 R11", "period ch0", per0, 20);
    check(wid0 == 10, "R2", "pulse width ch0", wid0, 10);
    check(wid3 == 6, "R7", "low-true width ch3", wid3, 6);
    check(pwm_out[1] == 0, "R9", "threshold at start", pwm_out[1], 0);
    check(pwm_out[2] == 1, "R9", "threshold at top", pwm_out[2], 1);
    check(flag[1] == 1 && flag[2] == 1, "R3", "flags on matches", flag, 4'b0110);

    // R8: new top value written mid-period, takes effect at turning point
    idle(5);
    wr(1, 9);
    idle(60);
    check(per0 == 12, "R8", "period after top change", per0, 12);
    check(wid0 == 10, "R8", "width after top change", wid0, 10);

    // R4 and R5: disable interrupts, clear flags
    for (int i = 0; i < NCH; i++) wr(5 + 2*i, (i == 3) ? 1 : 2);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(2); wr_data = CW'(4'hF);
    @(negedge clk);
    wr_en = 0;
    check(flag == {m_flag[3], m_flag[2], m_flag[1], m_flag[0]}, "R4", "flags after clear",
          flag, {m_flag[3], m_flag[2], m_flag[1], m_flag[0]});
    idle(30);
    check(irq == 0, "R5", "irq with enables off", irq, 0);

    // R6: release channel 3 pin with interrupt enabled
    wr(11, 3'b100);
    wr(2, 4'h8);
    idle(30);
    check(pwm_oe[3] == 0 && pwm_out[3] == 0, "R6", "released pin", {pwm_oe[3], pwm_out[3]}, 0);
    check(flag[3] == 1, "R6", "flag while released", flag[3], 1);
    check(irq == 1, "R6", "irq while released", irq, 1);

    // R1: top not above start holds counter, no further events
    wr(0, 12);
    idle(3);
    wr(2, 4'hF);
    idle(40);
    check(flag == 0, "R1", "no events when held", flag, 0);

    done = 1;
    report();
  end
endmodule